// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Software sets a divide value and an enable bit in a control register and a 16-bit timeout in a load register. A prescaler turns the system clock into count ticks, and a 16-bit down counter counts those ticks. Software must restart the counter from the load value before it runs out. It does this with a "kick", a write of the restart bit to the status register.

If the counter runs out while the block is enabled, the block raises a reset request for one clock cycle toward the system reset tree. It also sets a sticky reset-cause flag. The block has two reset inputs. The power-on reset clears everything. The warm reset is the one the system drives after a watchdog expiry. It clears all state except the reset-cause flag, so that software can see after the restart why the restart happened.

Top module: `tick_watchdog`

## Requirements
- R1: After the power-on reset, reads of control, load, status and reset-cause return 0, and `wdt_rst_req` is 0.
- R2: Control lives at offset 0x20. Bits 31:16 hold the divide value and bit 7 is the enable bit. All other bits read as 0. A write that clears bit 7 leaves the stored divide value in place.
- R3: While enabled, the prescaler produces one count tick every D clock cycles, where D is the divide value. A divide value of 0 behaves like 1.
- R4: Load lives at offset 0x24 and holds 16 bits in bits 15:0. Writing it does not change the running counter.
- R5: The status register lives at offset 0x00 and reads back the live counter in bits 15:0, with zeros above. A write to it with bit 9 set is a kick: the counter is reloaded from load and the prescaler phase restarts. A write to it with bit 9 clear has no effect.
- R6: A control write that sets bit 7 while the block is disabled reloads the counter from load and restarts the prescaler phase.
- R7: Take a reload edge with load N and divide D, where N=0 acts as 1. While enabled, `wdt_rst_req` is high in exactly the one cycle that follows clock edge N·D after the reload edge. The counter then reads 0 and stays there until the next reload.
- R8: While disabled, the counter does not move and `wdt_rst_req` stays 0.
- R9: The reset-cause flag reads in bit 1 of offset 0x38. Expiry sets it. A write with bit 1 set clears it, and so does the power-on reset. The warm reset leaves it unchanged and clears control, load and the counter.
- R10: When a kick falls on the same cycle as the final tick, the kick wins: no reset request is raised and the counter holds the load value.
- R11: When expiry falls on the same cycle as a write that clears the reset-cause flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| warm_rst_n | input | 1 | Synchronous active-low system reset; keeps the reset-cause flag |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Two pairs of functions can meet in one clock edge. The first pair is a kick and the final tick. The bench enables with divide 1 and load 3, and it times the kick so that it lands on the third edge after enabling. It then expects the status to read 3, no reset request, and a fresh full period of three cycles. The second pair is an expiry and a cause-clear write. The bench lands a cause-clear write on the expiry edge and expects the flag to read set and the reset request to be high in that same cycle.

// File: rtl/twd_pkg.sv
// Shared constants for the prescaled watchdog: bus widths, register
// offsets and the bit positions that software and the bench decode.
// Assumes a 32-bit data bus and byte offsets on an 8-bit address.
package twd_pkg;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int CNT_W    = 16;
    localparam int DIV_W    = 16;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h38;

    localparam int KICK_BIT  = 9;
    localparam int EN_BIT    = 7;
    localparam int DIV_LSB   = 16;
    localparam int CAUSE_BIT = 1;
endpackage

// File: rtl/twd_regs.sv
// Register file of the watchdog. It decodes bus writes into control,
// load and reset-cause state, forms the kick and the reload strobes,
// and muxes the read data. It assumes at most one write per cycle. The
// cause flag is reset only by por_n; the other state also clears on warm_n.
module twd_regs
    import twd_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [DIV_W-1:0]  div_q,
    output logic              en_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              cause_q,
    output logic              restart
);
    localparam int STAT_PAD = BUS_W - CNT_W;

    logic wr_stat, wr_ctrl, wr_load, wr_cause;
    logic kick, en_rise;

    // Decode which register the current bus write targets.
    always_comb begin
        wr_stat  = bus_we && (bus_addr == OFS_STAT);
        wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
        wr_load  = bus_we && (bus_addr == OFS_LOAD);
        wr_cause = bus_we && (bus_addr == OFS_CAUSE);
    end

    // Form the reload strobe from a kick or from a 0-to-1 change of enable.
    always_comb begin
        kick    = wr_stat && bus_wdata[KICK_BIT];
        en_rise = wr_ctrl && bus_wdata[EN_BIT] && !en_q;
        restart = kick || en_rise;
    end

    // Store the divide value and the enable bit.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_n) begin
            div_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_ctrl) begin
            div_q <= bus_wdata[DIV_LSB +: DIV_W];
            en_q  <= bus_wdata[EN_BIT];
        end
    end

    // Store the timeout value.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_n) begin
            load_q <= '0;
        end else if (wr_load) begin
            load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky reset cause: expiry sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (expire) begin
            cause_q <= 1'b1;
        end else if (wr_cause && bus_wdata[CAUSE_BIT]) begin
            cause_q <= 1'b0;
        end
    end

    // Return the addressed register on the read bus.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STAT:  bus_rdata = {{STAT_PAD{1'b0}}, cnt};
            OFS_CTRL: begin
                bus_rdata[DIV_LSB +: DIV_W] = div_q;
                bus_rdata[EN_BIT]           = en_q;
            end
            OFS_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
            OFS_CAUSE: bus_rdata[CAUSE_BIT] = cause_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/twd_prescaler.sv
// Clock divider for the watchdog. While enabled it emits one tick every
// div cycles, and a divide of 0 acts as 1. A restart puts the phase back
// to zero. While disabled the phase holds and no tick is produced.
module twd_prescaler
    import twd_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] phase_q;
    logic [W-1:0] last;

    // Find the last phase of a period, treating a divide of 0 as 1.
    always_comb begin
        last = (div == '0) ? '0 : div - 1'b1;
        tick = en && (phase_q >= last);
    end

    // Advance the phase and wrap it when a tick is produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/twd_countdown.sv
// Timeout counter of the watchdog. A restart loads it; each enabled tick
// decrements it. Expiry is the tick that would take the counter to zero,
// or a tick while it is at zero. The counter then parks at zero and is
// spent until the next restart, so the registered request is one cycle.
// A restart in the same cycle as a tick takes priority.
module twd_countdown
    import twd_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] load,
    output logic [W-1:0] cnt_q,
    output logic         expire,
    output logic         rst_req_q
);
    logic spent_q;

    // Detect the final tick of a live count.
    always_comb begin
        expire = en && tick && !restart && !spent_q && (cnt_q <= W'(1));
    end

    // Reload, count down, or park the counter after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else if (restart) begin
            cnt_q   <= load;
            spent_q <= 1'b0;
        end else if (expire) begin
            cnt_q   <= '0;
            spent_q <= 1'b1;
        end else if (en && tick && !spent_q) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Register the expiry into a one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= expire;
        end
    end
endmodule

// File: rtl/tick_watchdog.sv
// Top of the prescaled watchdog. It joins the register file, the
// prescaler and the timeout counter. The datapath takes the AND of both
// resets, while the register file sees them apart so the cause flag can
// outlive a warm reset. Both resets are synchronous and active-low.
module tick_watchdog
    import twd_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdt_rst_req
);
    logic             dp_rst_n;
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cause_q;
    logic             restart;
    logic             tick;
    logic             expire;

    // Combine both resets for the datapath.
    always_comb dp_rst_n = por_n && warm_rst_n;

    twd_regs u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .warm_n    (warm_rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_q),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .div_q     (div_q),
        .en_q      (en_q),
        .load_q    (load_q),
        .cause_q   (cause_q),
        .restart   (restart)
    );

    twd_prescaler #(.W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (dp_rst_n),
        .en      (en_q),
        .restart (restart),
        .div     (div_q),
        .tick    (tick)
    );

    twd_countdown #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (dp_rst_n),
        .en        (en_q),
        .restart   (restart),
        .tick      (tick),
        .load      (load_q),
        .cnt_q     (cnt_q),
        .expire    (expire),
        .rst_req_q (wdt_rst_req)
    );
endmodule

// File: rtl/twd_checker.sv
// Property checker for tick_watchdog. It watches the bus, the reset
// request and the internal counter, enable, load and cause state. It is
// attached by the bind below and is silent while either reset is active.
module twd_checker
    import twd_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              warm_rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              wdt_rst_req,
    input logic              en_q,
    input logic [CNT_W-1:0]  load_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cause_q
);
    // R7: the request never lasts two cycles
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    // R9: a request always comes with the cause flag set
    p_cause_on_req_r9: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        wdt_rst_req |-> cause_q);

    // R8: no request follows a disabled cycle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        !en_q |=> !wdt_rst_req);

    // R8: a disabled counter with a quiet bus holds its value
    p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (!en_q && !bus_we) |=> $stable(cnt_q));

    // R5: a kick reloads the counter from load
    p_kick_reload_r5: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (bus_we && bus_addr == OFS_STAT && bus_wdata[KICK_BIT]) |=> (cnt_q == $past(load_q)));

    // R4: a load write while disabled leaves the counter alone
    p_load_no_reload_r4: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (bus_we && bus_addr == OFS_LOAD && !en_q) |=> $stable(cnt_q));
endmodule

bind tick_watchdog twd_checker u_twd_checker (
    .clk         (clk),
    .por_n       (por_n),
    .warm_rst_n  (warm_rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .wdt_rst_req (wdt_rst_req),
    .en_q        (en_q),
    .load_q      (load_q),
    .cnt_q       (cnt_q),
    .cause_q     (cause_q)
);

// File: tb/test_tick_watchdog.sv
// Self-checking bench for tick_watchdog. A vector table of divide, load
// and expected cycles-to-request drives the main loop. Directed tests
// for reset state and corner cases follow it.
module test_tick_watchdog;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h20, A_LOAD = 8'h24, A_CAUSE = 8'h38;

    // {divide, load, expected cycles from enable edge to request}
    localparam logic [47:0] VECS [0:5] = '{
        {16'd3, 16'd4, 16'd12},
        {16'd1, 16'd5, 16'd5},
        {16'd0, 16'd3, 16'd3},
        {16'd5, 16'd1, 16'd5},
        {16'd2, 16'd0, 16'd2},
        {16'd7, 16'd3, 16'd21}
    };

    tick_watchdog i_tick_watchdog (
        .clk         (clk),
        .por_n       (por_n),
        .warm_rst_n  (warm_rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (wdt_rst_req) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        int k;
        int p0;
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, d);  check("R1 ctrl", d, 0);
        rd(A_LOAD, d);  check("R1 load", d, 0);
        rd(A_STAT, d);  check("R1 status", d, 0);
        rd(A_CAUSE, d); check("R1 cause", d, 0);
        check("R1 request", wdt_rst_req, 0);

        // R3 R7 R9: vector table walk
        for (int i = 0; i < 6; i++) begin
            logic [15:0] dv, ld, ex;
            dv = VECS[i][47:32]; ld = VECS[i][31:16]; ex = VECS[i][15:0];
            wr(A_CTRL, 32'h0);
            wr(A_CTRL, {dv, 16'h0});
            wr(A_LOAD, {16'h0, ld});
            wr(A_STAT, 32'h200);
            wr(A_CTRL, {dv, 16'h80});
            k = 0;
            do begin
                @(posedge clk); k++; @(negedge clk);
            end while (!wdt_rst_req && k < 2000);
            check("R3/R7 cycles to request", k, {16'h0, ex});
            @(negedge clk);
            check("R7 one-cycle request", wdt_rst_req, 0);
            rd(A_STAT, d);  check("R7 counter parked", d, 0);
            rd(A_CAUSE, d); check("R9 cause set", d, 32'h2);
            wr(A_CTRL, 32'h0);
            wr(A_CAUSE, 32'h2);
            rd(A_CAUSE, d); check("R9 cause cleared", d, 0);
        end

        // R2: field layout and enable clear keeps divide
        wr(A_CTRL, 32'hFFFF_FF7F);
        rd(A_CTRL, d); check("R2 unused bits read 0", d, 32'hFFFF_0000);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R2 enable set", d, 32'hFFFF_0080);
        wr(A_CTRL, 32'hFFFF_0000);
        rd(A_CTRL, d); check("R2 divide kept on disable", d, 32'hFFFF_0000);

        // R4 R5 R6: load write does not reload; kick does
        wr(A_LOAD, 32'd100);
        wr(A_CTRL, {16'd1000, 16'h80});
        rd(A_STAT, d); check("R6 enable reloads", d, 100);
        wr(A_LOAD, 32'd50);
        rd(A_STAT, d); check("R4 load write no reload", d, 100);
        wr(A_STAT, 32'h100);
        rd(A_STAT, d); check("R5 write without bit 9 ignored", d, 100);
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); check("R5 kick reloads", d, 50);
        rd(A_LOAD, d); check("R4 load readback", d, 50);
        wr(A_CTRL, 32'h0);

        // R8: stop sequence freezes the counter
        wr(A_LOAD, 32'd40);
        wr(A_CTRL, {16'd1, 16'h80});
        repeat (5) @(posedge clk);
        wr(A_STAT, 32'h200);
        wr(A_CTRL, {16'd1, 16'h0});
        rd(A_STAT, d); check("R8 count at stop", d, 39);
        p0 = pulses;
        repeat (100) @(posedge clk);
        rd(A_STAT, d); check("R8 frozen counter", d, 39);
        check("R8 no request while disabled", pulses, p0);

        // R10: kick on the final tick wins
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, {16'd1, 16'h80});
        repeat (2) @(posedge clk);
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); check("R10 counter reloaded", d, 3);
        check("R10 no request", wdt_rst_req, 0);
        k = 0;
        do begin
            @(posedge clk); k++; @(negedge clk);
        end while (!wdt_rst_req && k < 2000);
        check("R10 fresh period", k, 3);
        wr(A_CTRL, 32'h0);
        wr(A_CAUSE, 32'h2);

        // R11: expiry beats a cause-clear write in the same cycle
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, {16'd1, 16'h80});
        @(posedge clk);
        wr(A_CAUSE, 32'h2);
        rd(A_CAUSE, d); check("R11 set wins", d, 32'h2);
        check("R11 request present", wdt_rst_req, 1);

        // R9: warm reset keeps the cause, power-on clears it
        @(negedge clk) warm_rst_n = 1'b0;
        @(posedge clk); #1 warm_rst_n = 1'b1;
        rd(A_CTRL, d);  check("R9 warm clears ctrl", d, 0);
        rd(A_LOAD, d);  check("R9 warm clears load", d, 0);
        rd(A_STAT, d);  check("R9 warm clears counter", d, 0);
        rd(A_CAUSE, d); check("R9 cause survives warm", d, 32'h2);
        @(negedge clk) por_n = 1'b0;
        @(posedge clk); #1 por_n = 1'b1;
        rd(A_CAUSE, d); check("R9 power-on clears cause", d, 0);

        done = 1;
        finish_run();
    end
endmodule